// File: doc/BRIEF.md
# Multi-Port Receive Status Block Framer

This block gathers inbound traffic from several UART ports and turns it into fixed 128-byte blocks for one shared byte stream heading to a bulk-in endpoint. Each port offers received characters together with their line-status bytes, a one-cycle pulse when its transmitter runs empty, and a one-cycle pulse when its modem status changes, which also carries the new 8-bit modem status.

Every block opens with a four-byte header: the physical port number, an event token, a payload size, and the port's latest modem status. Data blocks carry character pairs from byte 4 onward, with the data byte first and its status byte second. Event blocks carry no payload. Unused bytes are zero. A consumer can join up to four blocks into one 512-byte transfer, because every block has the same length.

A data block closes when it holds 62 pairs, or when a port that holds at least one pair receives nothing more for 64 cycles. Ports with pending work are served in round-robin order. Within one port, a transmit-empty event goes first, then a modem change, then data.

Top module: `rx_block_framer`

## Requirements
- R1: Every block is exactly 128 bytes long, and `out_last` is high on the 128th byte only.
- R2: Byte 0 of a block holds the physical port index (0 to NPORTS-1).
- R3: Byte 1 is the token: 0x01 for received data, 0x03 for transmitter empty, 0x04 for modem status change.
- R4: Byte 2 is twice the number of pairs for a data block, so it is even and at most 124. It is 0 for tokens 0x03 and 0x04.
- R5: Byte 3 is the modem status value that came with the port's most recent modem-change pulse. It is 0 if no pulse has arrived since reset.
- R6: Payload starts at byte 4 as pairs in arrival order, with the data byte at the even offset and its status byte at the odd offset. All bytes past the payload are 0.
- R7: A data block closes when 62 pairs have been accepted. From then until its last byte has been sent, that port's `rx_ready` is low.
- R8: A data block with at least one pair closes 64 cycles after the last accepted pair. It is not emitted before then.
- R9: Within one port, a pending transmit-empty event is sent before a pending modem change, and both are sent before a closed data block.
- R10: When several ports have pending work, grants rotate, starting with the port after the one last served.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R12: After reset, `out_valid` is low and every `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | NPORTS | Per-port character pair valid |
| rx_data | input | NPORTS*8 | Per-port received character (port p at bits p*8+:8) |
| rx_stat | input | NPORTS*8 | Per-port line-status byte for that character |
| rx_ready | output | NPORTS | Per-port pair accepted when high with rx_valid |
| txe_evt | input | NPORTS | Per-port transmitter-empty pulse |
| msr_evt | input | NPORTS | Per-port modem-status-change pulse |
| msr_val | input | NPORTS*8 | Modem status captured with msr_evt |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a 128-byte block |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The assertions check the following on every cycle: the output holds while it is stalled, the header size byte is even and in range, the token and port bytes are legal, a port never stores more than 62 pairs, a closed port stays closed until its block has gone out, and the arbiter grants at most one port and only a port that is requesting. Only the bench scenarios can show the rest: the full contents of each block, the exact moment the idle timeout fires, the priority order among one port's events, and the rotation order across ports. These depend on stimulus arriving while the output is stalled, so they are checked against blocks the bench rebuilds from its own model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int HDR_BYTES = 4;

    typedef enum logic [7:0] {
        TOK_DATA = 8'h01,
        TOK_TXE  = 8'h03,
        TOK_MSR  = 8'h04
    } tok_e;

    typedef enum logic {
        EM_IDLE,
        EM_SEND
    } em_state_e;

    // pair layout: data byte in [15:8], line status in [7:0]
    function automatic logic [7:0] pair_byte(input logic [15:0] pair, input logic odd);
        return odd ? pair[7:0] : pair[15:8];
    endfunction

    function automatic tok_e pick_token(input logic txe, input logic msr);
        if (txe)      return TOK_TXE;
        else if (msr) return TOK_MSR;
        else          return TOK_DATA;
    endfunction
endpackage

// File: rtl/rxf_port_buf.sv
module rxf_port_buf #(
    parameter int MAX_PAIRS = 62,
    parameter int IDLE_CYC  = 64,
    localparam int CW = $clog2(MAX_PAIRS + 1),
    localparam int TW = $clog2(IDLE_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic [7:0]    rx_stat,
    output logic          rx_ready,
    input  logic          txe_evt,
    input  logic          msr_evt,
    input  logic [7:0]    msr_val,
    input  logic          clr_txe,
    input  logic          clr_msr,
    input  logic          clr_dat,
    output logic          req_txe,
    output logic          req_msr,
    output logic          req_dat,
    output logic [7:0]    msr_cur,
    output logic [CW-1:0] npairs,
    input  logic [CW-1:0] rd_idx,
    output logic [15:0]   rd_pair
);
    logic [15:0]   mem [MAX_PAIRS];
    logic [CW-1:0] count;
    logic [TW-1:0] idle;
    logic          closed;
    logic          accept;

    assign rx_ready = !closed;
    assign accept   = rx_valid && rx_ready;
    assign req_dat  = closed;
    assign npairs   = count;
    assign rd_pair  = (rd_idx < CW'(MAX_PAIRS)) ? mem[rd_idx] : 16'h0;

    always_ff @(posedge clk) begin
        if (accept) mem[count] <= {rx_data, rx_stat};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            idle   <= '0;
            closed <= 1'b0;
        end else if (clr_dat) begin
            count  <= '0;
            idle   <= '0;
            closed <= 1'b0;
        end else if (accept) begin
            count <= count + 1'b1;
            idle  <= '0;
            if (count == CW'(MAX_PAIRS - 1)) closed <= 1'b1;
        end else if (count != '0 && !closed) begin
            if (idle == TW'(IDLE_CYC - 1)) closed <= 1'b1;
            else                           idle   <= idle + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_txe <= 1'b0;
            req_msr <= 1'b0;
            msr_cur <= 8'h00;
        end else begin
            req_txe <= (req_txe && !clr_txe) || txe_evt;
            req_msr <= (req_msr && !clr_msr) || msr_evt;
            if (msr_evt) msr_cur <= msr_val;
        end
    end

    // R7: storage never exceeds one block of pairs
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(MAX_PAIRS));
    // R7: a closed port stays closed until its block is released
    a_r7_hold_closed: assert property (@(posedge clk) disable iff (rst)
        closed && !clr_dat |=> closed && !rx_ready);
    // R7: a full store is closed
    a_r7_full_closed: assert property (@(posedge clk) disable iff (rst)
        count == CW'(MAX_PAIRS) |-> closed);
endmodule

// File: rtl/rxf_rr_arb.sv
module rxf_rr_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] gnt_idx,
    output logic [N-1:0]  gnt
);
    logic [IW-1:0] last;
    int            cand;

    always_comb begin
        any     = 1'b0;
        gnt_idx = '0;
        cand    = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last) + k) % N;
            if (!any && req[cand]) begin
                any     = 1'b1;
                gnt_idx = IW'(cand);
            end
        end
        gnt = any ? (N'(1) << gnt_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)       last <= IW'(N - 1);
        else if (take) last <= gnt_idx;
    end

    // R10: at most one port granted, and only a requesting one
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r10_req_granted: assert property (@(posedge clk) disable iff (rst)
        take |-> req[gnt_idx]);
endmodule

// File: rtl/rx_block_framer.sv
module rx_block_framer
    import rxf_pkg::*;
#(
    parameter int NPORTS    = 4,
    parameter int BLK_BYTES = 128,
    parameter int IDLE_CYC  = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORTS-1:0]   rx_valid,
    input  logic [NPORTS*8-1:0] rx_data,
    input  logic [NPORTS*8-1:0] rx_stat,
    output logic [NPORTS-1:0]   rx_ready,
    input  logic [NPORTS-1:0]   txe_evt,
    input  logic [NPORTS-1:0]   msr_evt,
    input  logic [NPORTS*8-1:0] msr_val,
    output logic                out_valid,
    output logic [7:0]          out_data,
    output logic                out_last,
    input  logic                out_ready
);
    localparam int MAX_PAIRS = (BLK_BYTES - HDR_BYTES) / 2;
    localparam int CW        = $clog2(MAX_PAIRS + 1);
    localparam int BW        = $clog2(BLK_BYTES);
    localparam int IW        = $clog2(NPORTS);

    logic [NPORTS-1:0] req_txe, req_msr, req_dat, req_any;
    logic [NPORTS-1:0] clr_txe, clr_msr, clr_dat, gnt;
    logic [7:0]        msr_cur [NPORTS];
    logic [CW-1:0]     npairs  [NPORTS];
    logic [15:0]       rd_pair [NPORTS];
    logic [CW-1:0]     rd_idx;

    em_state_e     state;
    logic [BW-1:0] byte_idx;
    logic [IW-1:0] cur_port;
    tok_e          cur_tok;
    logic [7:0]    cur_size;
    logic [7:0]    cur_msr;

    logic          any, start, finish;
    logic [IW-1:0] gnt_idx;
    tok_e          sel_tok;
    logic [BW-1:0] off;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rxf_port_buf #(.MAX_PAIRS(MAX_PAIRS), .IDLE_CYC(IDLE_CYC)) i_buf (
            .clk(clk), .rst(rst),
            .rx_valid(rx_valid[p]), .rx_data(rx_data[p*8 +: 8]),
            .rx_stat(rx_stat[p*8 +: 8]), .rx_ready(rx_ready[p]),
            .txe_evt(txe_evt[p]), .msr_evt(msr_evt[p]), .msr_val(msr_val[p*8 +: 8]),
            .clr_txe(clr_txe[p]), .clr_msr(clr_msr[p]), .clr_dat(clr_dat[p]),
            .req_txe(req_txe[p]), .req_msr(req_msr[p]), .req_dat(req_dat[p]),
            .msr_cur(msr_cur[p]), .npairs(npairs[p]),
            .rd_idx(rd_idx), .rd_pair(rd_pair[p])
        );
        assign req_any[p] = req_txe[p] || req_msr[p] || req_dat[p];
        assign clr_txe[p] = start && gnt[p] && sel_tok == TOK_TXE;
        assign clr_msr[p] = start && gnt[p] && sel_tok == TOK_MSR;
        assign clr_dat[p] = finish && cur_port == IW'(p) && cur_tok == TOK_DATA;
    end

    rxf_rr_arb #(.N(NPORTS)) i_arb (
        .clk(clk), .rst(rst), .req(req_any), .take(start),
        .any(any), .gnt_idx(gnt_idx), .gnt(gnt)
    );

    assign sel_tok = pick_token(req_txe[gnt_idx], req_msr[gnt_idx]);
    assign start   = state == EM_IDLE && any;
    assign finish  = state == EM_SEND && out_ready && byte_idx == BW'(BLK_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= EM_IDLE;
            byte_idx <= '0;
            cur_port <= '0;
            cur_tok  <= TOK_DATA;
            cur_size <= 8'h00;
            cur_msr  <= 8'h00;
        end else if (start) begin
            state    <= EM_SEND;
            byte_idx <= '0;
            cur_port <= gnt_idx;
            cur_tok  <= sel_tok;
            cur_size <= (sel_tok == TOK_DATA) ? 8'({npairs[gnt_idx], 1'b0}) : 8'h00;
            cur_msr  <= msr_cur[gnt_idx];
        end else if (state == EM_SEND && out_ready) begin
            byte_idx <= byte_idx + 1'b1;
            if (finish) state <= EM_IDLE;
        end
    end

    assign off    = byte_idx - BW'(HDR_BYTES);
    assign rd_idx = CW'(off >> 1);

    always_comb begin
        out_valid = state == EM_SEND;
        out_last  = out_valid && byte_idx == BW'(BLK_BYTES - 1);
        case (byte_idx)
            BW'(0):  out_data = 8'(cur_port);
            BW'(1):  out_data = cur_tok;
            BW'(2):  out_data = cur_size;
            BW'(3):  out_data = cur_msr;
            default: out_data = (cur_tok == TOK_DATA && 8'(off) < cur_size)
                                ? pair_byte(rd_pair[cur_port], off[0]) : 8'h00;
        endcase
    end

    // R11: stalled output holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
    // R4: size byte even and within one block
    a_r4_size_even: assert property (@(posedge clk) disable iff (rst)
        out_valid && byte_idx == BW'(2) |-> !out_data[0] && out_data <= 8'(BLK_BYTES - HDR_BYTES));
    // R3: legal token
    a_r3_token: assert property (@(posedge clk) disable iff (rst)
        out_valid && byte_idx == BW'(1) |->
        (out_data == 8'h01 || out_data == 8'h03 || out_data == 8'h04));
    // R2: port byte in range
    a_r2_port: assert property (@(posedge clk) disable iff (rst)
        out_valid && byte_idx == BW'(0) |-> out_data < 8'(NPORTS));
    // R1: a block ends and the stream goes idle or restarts at the header
    a_r1_last_wraps: assert property (@(posedge clk) disable iff (rst)
        out_last && out_ready |=> !out_valid || byte_idx == '0);
endmodule

// File: tb/test_rx_block_framer.sv
module test_rx_block_framer;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   rx_valid = '0;
    logic [NP*8-1:0] rx_data = '0, rx_stat = '0, msr_val = '0;
    logic [NP-1:0]   rx_ready, txe_evt = '0, msr_evt = '0;
    logic            out_valid, out_last, out_ready = 1'b0;
    logic [7:0]      out_data;

    rx_block_framer i_rx_block_framer (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_stat(rx_stat),
        .rx_ready(rx_ready), .txe_evt(txe_evt), .msr_evt(msr_evt), .msr_val(msr_val),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    always #10 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int nblk = 0, bpos = 0;
    logic [7:0] blk [32][128];
    int lastpos [32];
    bit ready_en = 1'b0, throttle = 1'b0;
    logic [7:0] exp_msr [NP];
    logic [7:0] pl [124];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            nfail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // consumer: drive ready and capture bytes between edges
    always @(negedge clk) begin
        out_ready = ready_en && (!throttle || ($urandom % 3) != 0);
        if (out_valid && out_ready && nblk < 32) begin
            blk[nblk][bpos] = out_data;
            if (out_last || bpos == 127) begin
                lastpos[nblk] = out_last ? bpos : 999;
                nblk++;
                bpos = 0;
            end else bpos++;
        end
    end

    task automatic wait_blocks(input int n);
        int t = 0;
        while (nblk < n && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(nblk >= n, "R1 block count", nblk, n);
    endtask

    task automatic push(input int p, input logic [7:0] d, input logic [7:0] s);
        @(negedge clk);
        rx_valid[p] = 1'b1;
        rx_data[p*8 +: 8] = d;
        rx_stat[p*8 +: 8] = s;
        while (!rx_ready[p]) @(negedge clk);
        @(negedge clk);
        rx_valid[p] = 1'b0;
    endtask

    task automatic pulse(input logic [NP-1:0] txe, input logic [NP-1:0] msr, input logic [7:0] v);
        @(negedge clk);
        txe_evt = txe;
        msr_evt = msr;
        for (int p = 0; p < NP; p++) begin
            msr_val[p*8 +: 8] = v;
            if (msr[p]) exp_msr[p] = v;
        end
        @(negedge clk);
        txe_evt = '0;
        msr_evt = '0;
    endtask

    task automatic check_block(input int b, input int port, input int tok, input int npr);
        int bad = -1;
        check(lastpos[b] == 127, "R1 last position", lastpos[b], 127);
        check(blk[b][0] == 8'(port), "R2 port byte", blk[b][0], port);
        check(blk[b][1] == 8'(tok), "R3 token byte", blk[b][1], tok);
        check(blk[b][2] == 8'(2 * npr), "R4 size byte", blk[b][2], 2 * npr);
        check(blk[b][3] == exp_msr[port], "R5 modem byte", blk[b][3], exp_msr[port]);
        for (int i = 4; i < 128; i++) begin
            logic [7:0] e;
            e = (i - 4 < 2 * npr) ? pl[i - 4] : 8'h00;
            if (bad < 0 && blk[b][i] != e) bad = i;
        end
        check(bad < 0, "R6 payload and zero fill", bad, -1);
    endtask

    initial begin
        int base, n, p;
        logic [7:0] held;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NP; i++) exp_msr[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
        check(rx_ready == '1, "R12 rx_ready after reset", rx_ready, 4'hf);
        rst = 1'b0;
        ready_en = 1'b1;

        // R8: partial block on port 2 waits for idle timeout
        base = nblk;
        for (int i = 0; i < 3; i++) begin
            pl[2*i] = 8'h30 + 8'(i);
            pl[2*i+1] = 8'h60 + 8'(i);
            push(2, pl[2*i], pl[2*i+1]);
        end
        repeat (60) @(negedge clk);
        check(nblk == base && !out_valid, "R8 no block before timeout", nblk - base, 0);
        wait_blocks(base + 1);
        check_block(base, 2, 8'h01, 3);

        // R5/R3: modem change event on port 1
        base = nblk;
        pulse('0, 4'b0010, 8'hA5);
        wait_blocks(base + 1);
        for (int i = 0; i < 124; i++) pl[i] = 8'h00;
        check_block(base, 1, 8'h04, 0);

        // R9/R7/R11: stalled output, full block plus events on port 0
        base = nblk;
        ready_en = 1'b0;
        pulse(4'b1000, '0, 8'h00);
        for (int i = 0; i < 62; i++) begin
            pl[2*i] = 8'($urandom);
            pl[2*i+1] = 8'($urandom);
            push(0, pl[2*i], pl[2*i+1]);
        end
        check(rx_ready[0] == 1'b0, "R7 rx_ready low when full", rx_ready[0], 0);
        pulse(4'b0001, 4'b0001, 8'h3C);
        held = out_data;
        repeat (5) @(negedge clk);
        check(out_valid && out_data == held && held == 8'h03, "R11 stalled output held", out_data, held);
        ready_en = 1'b1;
        wait_blocks(base + 4);
        check(blk[base][0] == 8'h03 && blk[base][1] == 8'h03, "R9 first block port3 txe", blk[base][1], 3);
        check(blk[base+1][0] == 8'h00 && blk[base+1][1] == 8'h03, "R9 port0 txe first", blk[base+1][1], 3);
        check(blk[base+2][0] == 8'h00 && blk[base+2][1] == 8'h04, "R9 port0 msr second", blk[base+2][1], 4);
        check_block(base + 3, 0, 8'h01, 62);
        check(rx_ready[0] == 1'b1, "R7 rx_ready back after send", rx_ready[0], 1);

        // R10: rotation after port 2
        base = nblk;
        ready_en = 1'b0;
        pulse(4'b0100, '0, 8'h00);
        pulse(4'b1111, '0, 8'h00);
        ready_en = 1'b1;
        wait_blocks(base + 5);
        for (int i = 0; i < 5; i++) begin
            int ep;
            ep = (2 + i) % NP;
            check(blk[base+i][0] == 8'(ep) && blk[base+i][1] == 8'h03, "R10 rotation order", blk[base+i][0], ep);
        end

        // random data blocks with throttled consumer
        throttle = 1'b1;
        for (int r = 0; r < 8; r++) begin
            base = nblk;
            p = $urandom % NP;
            n = (r == 0) ? 62 : 1 + ($urandom % 62);
            for (int i = 0; i < n; i++) begin
                pl[2*i] = 8'($urandom);
                pl[2*i+1] = 8'($urandom);
                push(p, pl[2*i], pl[2*i+1]);
            end
            wait_blocks(base + 1);
            check_block(base, p, 8'h01, n);
        end

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule